// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a small set of one-bit ownership flags that let two agents, an on-chip firmware processor and a host driver, take turns using shared resources. Each agent reaches the bank through its own simple 32-bit register port. A register read is also the acquire operation. If the addressed flag is free, the read sets it and returns 1, so the reader now owns the resource. If the flag is already set, the read returns 0 and the flag does not change. To release a flag, its owner writes a word with bit 0 set to the same index.

Index 0 protects the management-bus (MDIO) mailbox and index 2 protects a shared RAM. The remaining indices are general purpose. Software retries a failed acquire on a slow poll of roughly 10 µs and gives up after roughly 100 ms. The bank therefore needs no queue and no timer. It only needs an indivisible test-and-set for each flag.

The firmware port has fixed priority over the driver port when both try to acquire the same free flag in the same cycle.

Top module: `hw_sem_bank`

## Requirements
- R1: After a synchronous reset, every flag is free, so the first read of each index returns 1, and neither port shows a read response while reset is held.
- R2: A read of a free flag returns the word 32'h0000_0001 with `*_rvalid` high exactly one cycle after the read is presented. The flag is marked taken in the same cycle.
- R3: A read of a taken flag returns 32'h0000_0000 and leaves the flag taken. This applies to the agent that already holds it as well.
- R4: A write whose data bit 0 is 1 releases the addressed flag, so the next read of that index returns 1.
- R5: A write whose data bit 0 is 0 has no effect, whatever the other 31 bits hold. The flag stays taken.
- R6: When both ports read the same free flag in the same cycle, the firmware port receives 1 and the driver port receives 0.
- R7: Both ports reading different free flags in the same cycle are both granted.
- R8: Flags are independent. Acquiring or releasing one index never changes the result of a read of another index, including the MDIO index 0 and the shared-RAM index 2.
- R9: When a taken flag is released by one port and read by the other in the same cycle, the read returns 0 and the flag is free afterwards.
- R10: Writes produce no read response. `*_rvalid` is high only in the cycle after a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_sel | input | 1 | Firmware port access strobe |
| fw_wr | input | 1 | Firmware access is a write (1) or a read (0) |
| fw_idx | input | 2 | Firmware flag index |
| fw_wdata | input | 32 | Firmware write data; bit 0 set releases the flag |
| fw_rvalid | output | 1 | Firmware read response valid |
| fw_rdata | output | 32 | Firmware read data: 1 = granted, 0 = busy |
| drv_sel | input | 1 | Driver port access strobe |
| drv_wr | input | 1 | Driver access is a write (1) or a read (0) |
| drv_idx | input | 2 | Driver flag index |
| drv_wdata | input | 32 | Driver write data; bit 0 set releases the flag |
| drv_rvalid | output | 1 | Driver read response valid |
| drv_rdata | output | 32 | Driver read data: 1 = granted, 0 = busy |

## Verification
Single-port reads of a free flag and of a held flag show whether the read really performs a test-and-set rather than a plain status read. Paired writes with bit 0 clear and with bit 0 set separate the release path from the ignored path. Simultaneous reads of the same index show the priority order. Simultaneous reads of different indices show that nothing is serialised that should not be. A release paired with a read of the same held flag fixes the precedence within a cycle. A reset in the middle of the run, taken while every flag is held, confirms that all flags clear.

// File: rtl/hw_sem_pkg.sv
package hw_sem_pkg;

    localparam int BUS_W     = 32;
    localparam int N_PORTS   = 2;
    localparam int PORT_FW   = 0;  // higher priority
    localparam int PORT_DRV  = 1;
    localparam int SEM_MDIO  = 0;
    localparam int SEM_SHRAM = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // per-port, per-flag request seen by a cell
    typedef struct packed {
        logic acquire;
        logic release_;
    } sem_hit_t;

    function automatic acc_kind_t classify(input logic sel, input logic wr);
        if (!sel)    return ACC_IDLE;
        else if (wr) return ACC_WRITE;
        else         return ACC_READ;
    endfunction

    function automatic logic is_release(input logic [BUS_W-1:0] w);
        return w[0];
    endfunction

    function automatic logic [BUS_W-1:0] grant_word(input logic g);
        return {{(BUS_W-1){1'b0}}, g};
    endfunction

endpackage

// File: rtl/hw_sem_decode.sv
module hw_sem_decode
    import hw_sem_pkg::*;
#(
    parameter int NUM_SEM = 4,
    parameter int IDX_W   = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic             sel,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic             wbit,
    output logic             is_read,
    output sem_hit_t         hits [NUM_SEM]
);
    acc_kind_t kind;

    always_comb kind = classify(sel, wr);
    always_comb is_read = (kind == ACC_READ);

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_hit
        logic match;
        always_comb match = (idx == IDX_W'(s));
        always_comb begin
            hits[s].acquire  = match && (kind == ACC_READ);
            hits[s].release_ = match && (kind == ACC_WRITE) && wbit;
        end
    end
endmodule

// File: rtl/hw_sem_cell.sv
module hw_sem_cell
    import hw_sem_pkg::*;
#(
    parameter int NPORT = N_PORTS
) (
    input  logic     clk,
    input  logic     rst,
    input  sem_hit_t req  [NPORT],
    output logic     gnt  [NPORT],
    output logic     taken
);
    logic [NPORT-1:0] acq_v;
    logic [NPORT-1:0] rel_v;
    logic [NPORT-1:0] gnt_v;

    for (genvar p = 0; p < NPORT; p++) begin : g_unpack
        always_comb acq_v[p] = req[p].acquire;
        always_comb rel_v[p] = req[p].release_;
        always_comb gnt[p]   = gnt_v[p];
    end

    // fixed priority: lowest port number wins a free flag
    always_comb begin
        gnt_v = '0;
        if (!taken) begin
            for (int p = 0; p < NPORT; p++) begin
                if (acq_v[p] && (gnt_v == '0)) gnt_v[p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              taken <= 1'b0;
        else if (|gnt_v)      taken <= 1'b1;
        else if (|rel_v)      taken <= 1'b0;
    end

    p_take_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(taken) |-> $past(|acq_v));
    p_hold_without_release_r5: assert property (@(posedge clk) disable iff (rst)
        (taken && !(|rel_v)) |=> taken);
    p_release_frees_r4: assert property (@(posedge clk) disable iff (rst)
        (taken && (|rel_v)) |=> !taken);
endmodule

// File: rtl/hw_sem_resp.sv
module hw_sem_resp
    import hw_sem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             is_read,
    input  logic             granted,
    output logic             rvalid,
    output logic [BUS_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= is_read;
            rdata  <= is_read ? grant_word(granted) : '0;
        end
    end

    p_resp_only_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(is_read));
    p_data_is_flag_r2: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rdata[BUS_W-1:1] == '0));
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank
    import hw_sem_pkg::*;
#(
    parameter int NUM_SEM = 4,
    parameter int IDX_W   = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fw_sel,
    input  logic             fw_wr,
    input  logic [IDX_W-1:0] fw_idx,
    input  logic [31:0]      fw_wdata,
    output logic             fw_rvalid,
    output logic [31:0]      fw_rdata,
    input  logic             drv_sel,
    input  logic             drv_wr,
    input  logic [IDX_W-1:0] drv_idx,
    input  logic [31:0]      drv_wdata,
    output logic             drv_rvalid,
    output logic [31:0]      drv_rdata
);
    logic             p_sel   [N_PORTS];
    logic             p_wr    [N_PORTS];
    logic [IDX_W-1:0] p_idx   [N_PORTS];
    logic             p_wbit  [N_PORTS];
    logic             p_isrd  [N_PORTS];
    logic             p_gnt   [N_PORTS];
    logic             p_rv    [N_PORTS];
    logic [BUS_W-1:0] p_rd    [N_PORTS];
    sem_hit_t         hit_ps  [N_PORTS][NUM_SEM];
    logic [NUM_SEM-1:0] gnt_ps [N_PORTS];
    logic [NUM_SEM-1:0] sem_taken;
    logic             wdata_unused;

    always_comb begin
        p_sel[PORT_FW]  = fw_sel;   p_sel[PORT_DRV]  = drv_sel;
        p_wr[PORT_FW]   = fw_wr;    p_wr[PORT_DRV]   = drv_wr;
        p_idx[PORT_FW]  = fw_idx;   p_idx[PORT_DRV]  = drv_idx;
        p_wbit[PORT_FW] = is_release(fw_wdata);
        p_wbit[PORT_DRV] = is_release(drv_wdata);
        wdata_unused = ^{fw_wdata[31:1], drv_wdata[31:1], sem_taken};
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        hw_sem_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec (
            .sel(p_sel[p]), .wr(p_wr[p]), .idx(p_idx[p]), .wbit(p_wbit[p]),
            .is_read(p_isrd[p]), .hits(hit_ps[p])
        );
        always_comb p_gnt[p] = |gnt_ps[p];
        hw_sem_resp u_resp (
            .clk(clk), .rst(rst), .is_read(p_isrd[p]), .granted(p_gnt[p]),
            .rvalid(p_rv[p]), .rdata(p_rd[p])
        );
    end

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        sem_hit_t req_s [N_PORTS];
        logic     gnt_s [N_PORTS];
        for (genvar p = 0; p < N_PORTS; p++) begin : g_route
            always_comb req_s[p] = hit_ps[p][s];
            always_comb gnt_ps[p][s] = gnt_s[p];
        end
        hw_sem_cell #(.NPORT(N_PORTS)) u_cell (
            .clk(clk), .rst(rst), .req(req_s), .gnt(gnt_s), .taken(sem_taken[s])
        );
    end

    always_comb begin
        fw_rvalid  = p_rv[PORT_FW];
        fw_rdata   = p_rd[PORT_FW];
        drv_rvalid = p_rv[PORT_DRV];
        drv_rdata  = p_rd[PORT_DRV];
    end

    p_single_winner_r6: assert property (@(posedge clk) disable iff (rst)
        $past(fw_sel && !fw_wr && drv_sel && !drv_wr && (fw_idx == drv_idx))
        |-> !(fw_rdata[0] && drv_rdata[0]));
    p_idle_in_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!fw_rvalid && !drv_rvalid));
endmodule

// File: tb/hw_sem_bank_tb.sv
`timescale 1ns/1ps
module hw_sem_bank_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fw_sel = 0, fw_wr = 0, drv_sel = 0, drv_wr = 0;
    logic [1:0] fw_idx = 0, drv_idx = 0;
    logic [31:0] fw_wdata = 0, drv_wdata = 0;
    logic fw_rvalid, drv_rvalid;
    logic [31:0] fw_rdata, drv_rdata;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hw_sem_bank u_dut (
        .clk(clk), .rst(rst),
        .fw_sel(fw_sel), .fw_wr(fw_wr), .fw_idx(fw_idx), .fw_wdata(fw_wdata),
        .fw_rvalid(fw_rvalid), .fw_rdata(fw_rdata),
        .drv_sel(drv_sel), .drv_wr(drv_wr), .drv_idx(drv_idx), .drv_wdata(drv_wdata),
        .drv_rvalid(drv_rvalid), .drv_rdata(drv_rdata)
    );

    // entry: fw_op[13:12] fw_idx[11:10] fw_w0[9] drv_op[8:7] drv_idx[6:5] drv_w0[4]
    //        exp_fw_v[3] exp_fw_d[2] exp_drv_v[1] exp_drv_d[0]; op 0 idle, 1 read, 2 write
    localparam int NV = 14;
    localparam logic [13:0] VEC [NV] = '{
        {2'd1,2'd0,1'b0, 2'd0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0}, // R2 fw takes MDIO
        {2'd0,2'd0,1'b0, 2'd1,2'd0,1'b0, 1'b0,1'b0,1'b1,1'b0}, // R3 drv busy
        {2'd1,2'd0,1'b0, 2'd0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R3 holder busy
        {2'd0,2'd0,1'b0, 2'd2,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // R10 write 0
        {2'd0,2'd0,1'b0, 2'd1,2'd0,1'b0, 1'b0,1'b0,1'b1,1'b0}, // R5 still held
        {2'd2,2'd0,1'b1, 2'd0,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0}, // R4 release
        {2'd0,2'd0,1'b0, 2'd1,2'd0,1'b0, 1'b0,1'b0,1'b1,1'b1}, // R4 drv takes
        {2'd1,2'd2,1'b0, 2'd1,2'd2,1'b0, 1'b1,1'b1,1'b1,1'b0}, // R6 shared RAM race
        {2'd1,2'd1,1'b0, 2'd1,2'd3,1'b0, 1'b1,1'b1,1'b1,1'b1}, // R7 different flags
        {2'd2,2'd2,1'b1, 2'd1,2'd2,1'b0, 1'b0,1'b0,1'b1,1'b0}, // R9 release+read
        {2'd0,2'd0,1'b0, 2'd1,2'd2,1'b0, 1'b0,1'b0,1'b1,1'b1}, // R9 now free
        {2'd1,2'd0,1'b0, 2'd0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R8 MDIO held by drv
        {2'd1,2'd3,1'b0, 2'd2,2'd0,1'b1, 1'b1,1'b0,1'b0,1'b0}, // R8 idx3 unaffected
        {2'd1,2'd0,1'b0, 2'd1,2'd0,1'b0, 1'b1,1'b1,1'b1,1'b0}  // R6 MDIO race
    };

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2";  1, 2: return "R3";  3: return "R10"; 4: return "R5";
            5, 6: return "R4"; 7, 13: return "R6"; 8: return "R7";
            9, 10: return "R9"; default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] fop, input logic [1:0] fi, input logic [31:0] fw,
                         input logic [1:0] dop, input logic [1:0] di, input logic [31:0] dw);
        @(negedge clk);
        fw_sel = (fop != 0); fw_wr = (fop == 2); fw_idx = fi; fw_wdata = fw;
        drv_sel = (dop != 0); drv_wr = (dop == 2); drv_idx = di; drv_wdata = dw;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        fw_sel = 0; drv_sel = 0; fw_wr = 0; drv_wr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 fw_rvalid in reset", {31'b0, fw_rvalid}, 32'h0);
        chk("R1 drv_rvalid in reset", {31'b0, drv_rvalid}, 32'h0);
        @(negedge clk); rst = 0;

        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            drive(v[13:12], v[11:10], {31'b0, v[9]}, v[8:7], v[6:5], {31'b0, v[4]});
            chk(tag_of(i), {31'b0, fw_rvalid}, {31'b0, v[3]});
            if (v[3]) chk(tag_of(i), fw_rdata, {31'b0, v[2]});
            chk(tag_of(i), {31'b0, drv_rvalid}, {31'b0, v[1]});
            if (v[1]) chk(tag_of(i), drv_rdata, {31'b0, v[0]});
        end
        idle();

        // R1: reset mid-run clears every held flag
        @(negedge clk); rst = 1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 rvalid low in reset", {31'b0, fw_rvalid}, 32'h0);
        @(negedge clk); rst = 0;
        for (int s = 0; s < 4; s++) begin
            drive(2'd1, 2'(s), 32'h0, 2'd0, 2'd0, 32'h0);
            chk("R1 free after reset", fw_rdata, 32'h1);
        end
        // R5: write with only upper bits set leaves flag 0 held
        drive(2'd0, 2'd0, 32'h0, 2'd2, 2'd0, 32'hFFFF_FFFE);
        chk("R10 no resp on write", {31'b0, drv_rvalid}, 32'h0);
        drive(2'd0, 2'd0, 32'h0, 2'd1, 2'd0, 32'h0);
        chk("R5 upper bits ignored", drv_rdata, 32'h0);
        // R4: drv releases a flag fw took, then acquires it
        drive(2'd0, 2'd0, 32'h0, 2'd2, 2'd0, 32'h1);
        drive(2'd0, 2'd0, 32'h0, 2'd1, 2'd0, 32'h0);
        chk("R4 released by other port", drv_rdata, 32'h1);
        // R8: index 2 still held by fw
        drive(2'd0, 2'd0, 32'h0, 2'd1, 2'd2, 32'h0);
        chk("R8 shared RAM flag still held", drv_rdata, 32'h0);
        idle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule